// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets a host reach the management registers of external PHYs over a two-wire MDC/MDIO bus. The host talks to it through a small 32-bit register port. A single command register both launches an operation and, once the operation ends, returns its result. A cause register and a mask register turn completion into a level interrupt, so software can either poll the busy flag or sleep until the interrupt arrives.

A write to the command register is taken only while the block is idle. The block then builds a complete Clause 22 frame and shifts it out MSB first. MDC comes from a programmable divider of the system clock. New bits are launched after the falling edge of MDC. During a read, the block stops driving MDIO from the turnaround onward and samples the PHY's data on each rising MDC edge. For a write, the data travels in the same register write that starts the frame, so no second host access is needed.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Command register at offset 0x00: bits [15:0] data, [20:16] PHY address, [25:21] register number, bit 26 operation (1 read, 0 write). Bit 28 reads 1 from the clock edge that accepts a command until the frame ends. Bits 31:29 read 0.
- R2: Each frame is 64 bits sent MSB first: 32 ones, start 01, opcode 10 (read) or 01 (write), 5-bit PHY address, 5-bit register number, turnaround (10 on writes), then 16 data bits. Each bit is valid on the rising edge of MDC.
- R3: On a read, MDIO output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled on MDC rising edges (first sampled is bit 15) appear in command bits [15:0], and bit 27 (read-valid) is set.
- R4: A command-register write made while bit 28 is 1 is ignored. It starts no frame and changes no command field.
- R5: Read-valid is cleared when a new command is accepted, and stays 0 after a write completes.
- R6: Every completed frame sets bit 4 of the cause register at offset 0x7C.
- R7: Writing the cause register with bit 4 = 0 clears the cause bit. Writing bit 4 = 1 leaves it unchanged. Other cause bits read 0.
- R8: Mask register at offset 0x80 holds bit 4 and reads it back. The irq output is 1 exactly while the cause bit and the mask bit are both 1.
- R9: MDC idles low. While a frame runs, each MDC half period lasts DIV_HALF system clocks, a frame has 64 MDC rising edges, and busy lasts exactly 128*DIV_HALF clocks.
- R10: After reset, all three registers read 0, and MDC, MDIO output enable and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions assume that every host write is a one-cycle strobe. They also assume the PHY changes mdio_i only after a falling MDC edge, so that the value is settled several system clocks before the rising edge that samples it. The bench's PHY model updates its data bit on each falling MDC edge, and the bench drives host strokes only at falling system-clock edges. Random commands, including the back-to-back and busy-collision cases, are issued only through those tasks.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = 7;
    localparam int TA_IDX    = 46;   // first turnaround bit position in frame order
    localparam int DATA_IDX  = 48;   // first data bit position in frame order

    localparam int OP_BIT    = 26;
    localparam int RV_BIT    = 27;
    localparam int BUSY_BIT  = 28;
    localparam int DONE_BIT  = 4;

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_CAUSE = 8'h7C;
    localparam logic [7:0] OFS_MASK  = 8'h80;

    typedef struct packed {
        logic        rd;
        logic [4:0]  regad;
        logic [4:0]  phy;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] pay;
        opc = c.rd ? 2'b10 : 2'b01;
        ta  = c.rd ? 2'b11 : 2'b10;
        pay = c.rd ? 16'hFFFF : c.data;
        return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.regad, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t q, d;

    always_comb begin
        d      = q;
        rise_p = 1'b0;
        fall_p = 1'b0;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (q.cnt == CNT_LAST) begin
            d.cnt  = '0;
            d.mdc  = !q.mdc;
            rise_p = !q.mdc;
            fall_p = q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    assert_mdc_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    assert_half_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.cnt != CNT_LAST) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_p,
    input  logic        fall_p,
    input  logic        mdio_i,
    output logic        run,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_IDX);

    typedef struct packed {
        logic                 run;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [15:0]          cap;
    } seq_state_t;

    seq_state_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.run) begin
            if (start) begin
                d.run = 1'b1;
                d.rd  = cmd.rd;
                d.idx = '0;
                d.sh  = build_frame(cmd);
                d.cap = '0;
            end
        end else begin
            if (rise_p && q.rd && q.idx >= IDX_DATA) begin
                d.cap = {q.cap[14:0], mdio_i};
            end
            if (fall_p) begin
                if (q.idx == IDX_LAST) begin
                    d.run = 1'b0;
                    done  = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.sh  = {q.sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run     = q.run;
    assign mdio_o  = q.run ? q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = q.run && !(q.rd && q.idx >= IDX_TA);
    assign rd_data = q.cap;

    assert_ta_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.rd && fall_p && q.idx == IDX_TA - 1'b1) |=> !mdio_oe);
    assert_edge_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_p && fall_p));
    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !fall_p) |=> $stable(mdio_o));

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done,
    input  logic [15:0]       rd_data,
    output logic              start,
    output mdio_cmd_t         cmd,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

    typedef struct packed {
        logic        busy;
        logic        rv;
        mdio_cmd_t   c;
        logic        cause;
        logic        mask;
    } reg_state_t;

    reg_state_t q, d;
    logic       unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:27]};

    always_comb begin
        d     = q;
        start = bus_wr && (bus_addr == A_CMD) && !q.busy;
        if (start) begin
            d.busy    = 1'b1;
            d.rv      = 1'b0;
            d.c.rd    = bus_wdata[OP_BIT];
            d.c.regad = bus_wdata[25:21];
            d.c.phy   = bus_wdata[20:16];
            d.c.data  = bus_wdata[15:0];
        end
        if (bus_wr && bus_addr == A_CAUSE && !bus_wdata[DONE_BIT]) begin
            d.cause = 1'b0;
        end
        if (bus_wr && bus_addr == A_MASK) begin
            d.mask = bus_wdata[DONE_BIT];
        end
        if (done) begin
            d.busy  = 1'b0;
            d.cause = 1'b1;
            if (q.c.rd) begin
                d.rv     = 1'b1;
                d.c.data = rd_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD) begin
            bus_rdata[15:0]     = q.c.data;
            bus_rdata[20:16]    = q.c.phy;
            bus_rdata[25:21]    = q.c.regad;
            bus_rdata[OP_BIT]   = q.c.rd;
            bus_rdata[RV_BIT]   = q.rv;
            bus_rdata[BUSY_BIT] = q.busy;
        end else if (bus_addr == A_CAUSE) begin
            bus_rdata[DONE_BIT] = q.cause;
        end else if (bus_addr == A_MASK) begin
            bus_rdata[DONE_BIT] = q.mask;
        end
    end

    assign cmd = d.c;
    assign irq = q.cause && q.mask;

    assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !done) |=> q.busy);
    assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && bus_wr && bus_addr == A_CMD)
        |=> ($stable(q.c.phy) && $stable(q.c.regad) && $stable(q.c.rd)));
    assert_rv_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !q.rv);
    assert_cause_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> q.cause);
    assert_irq_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.mask && !(bus_wr && bus_addr == A_MASK)) |=> irq);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              irq
);
    logic        start;
    logic        done;
    logic        run;
    logic        rise_p;
    logic        fall_p;
    logic [15:0] rd_data;
    mdio_cmd_t   cmd;

    mdio_host_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .done(done), .rd_data(rd_data),
        .start(start), .cmd(cmd), .irq(irq)
    );

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) div_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p)
    );

    mdio_frame_seq seq_i (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cmd(cmd),
        .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
        .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .done(done), .rd_data(rd_data)
    );

    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);
    assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!mdio_oe && !mdc));

endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, irq;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    int          bitn = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] resp = '0;
    time         t_r1 = 0;
    time         t_r2 = 0;

    always #10 clk = !clk;

    mdio_mgmt_master #(.DIV_HALF(H), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
    );

    // PHY model
    always @(posedge mdc) begin
        if (bitn < 64) begin
            cap_o[63-bitn]  = mdio_o;
            cap_oe[63-bitn] = mdio_oe;
        end
        if (bitn == 0) t_r1 = $time;
        if (bitn == 1) t_r2 = $time;
        bitn = bitn + 1;
    end
    always @(negedge mdc) begin
        if (bitn >= 48 && bitn < 64) mdio_i = resp[63-bitn];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] dat);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, dat};
    endfunction

    function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] phy,
                                             input logic [4:0] ra, input logic [15:0] dat);
        return {5'b0, rd, ra, phy, dat};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_read(8'h00, v);
            if (!v[28]) break;
            @(negedge clk);
        end
    endtask

    task automatic launch(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] dat, input logic [15:0] r);
        bitn = 0; mdio_i = 1'b1; resp = r;
        bus_write(8'h00, cmd_word(rd, phy, ra, dat));
    endtask

    task automatic check_result(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                                input logic [15:0] dat, input logic [15:0] r);
        logic [31:0] v;
        logic [63:0] ef;
        ef = exp_frame(rd, phy, ra, dat);
        chk("R9 rising edge count", 64'(bitn), 64'd64);
        if (rd) begin
            chk("R2 read frame header", {46'b0, cap_o[63:18]}, {46'b0, ef[63:18]});
            chk("R3 read oe pattern", cap_oe, {{46{1'b1}}, 18'b0});
        end else begin
            chk("R2 write frame", cap_o, ef);
            chk("R2 write oe", cap_oe, {64{1'b1}});
        end
        bus_read(8'h00, v);
        chk("R1 R3 R5 command readback", 64'(v),
            64'({3'b0, 1'b0, rd, rd, ra, phy, (rd ? r : dat)}));
        bus_read(8'h7C, v);
        chk("R6 cause set", 64'(v), 64'h10);
    endtask

    task automatic full_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] dat, input logic [15:0] r);
        launch(rd, phy, ra, dat, r);
        wait_idle();
        check_result(rd, phy, ra, dat, r);
        bus_write(8'h7C, 32'h0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        bus_read(8'h00, v); chk("R10 cmd reset", 64'(v), 64'h0);
        bus_read(8'h7C, v); chk("R10 cause reset", 64'(v), 64'h0);
        bus_read(8'h80, v); chk("R10 mask reset", 64'(v), 64'h0);
        chk("R10 pins reset", {61'b0, mdc, mdio_oe, irq}, 64'h0);

        // R9 busy length and MDC period, R1 busy flag
        launch(1'b0, 5'h11, 5'h0A, 16'hBEEF, 16'h0);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h00, v);
            if (!v[28]) break;
            n++;
            @(negedge clk);
        end
        chk("R1 R9 busy cycles", 64'(n), 64'(128*H));
        chk("R9 mdc period", 64'(t_r2 - t_r1), 64'(2*H*20));
        chk("R9 mdc idle low", {63'b0, mdc}, 64'h0);
        check_result(1'b0, 5'h11, 5'h0A, 16'hBEEF, 16'h0);

        // R7 writing 1 keeps cause, writing 0 clears
        bus_write(8'h7C, 32'hFFFF_FFFF);
        bus_read(8'h7C, v); chk("R7 write one no effect", 64'(v), 64'h10);
        bus_write(8'h7C, 32'hFFFF_FFEF);
        bus_read(8'h7C, v); chk("R7 write zero clears", 64'(v), 64'h0);

        // R3 directed read with edge data patterns
        full_cmd(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF);
        full_cmd(1'b1, 5'h00, 5'h00, 16'h1234, 16'h8001);

        // R5 read-valid cleared on new accept
        launch(1'b0, 5'h03, 5'h04, 16'h5555, 16'h0);
        repeat (10) @(negedge clk);
        bus_read(8'h00, v);
        chk("R5 rv cleared while busy", {62'b0, v[28], v[27]}, 64'h2);
        wait_idle();
        check_result(1'b0, 5'h03, 5'h04, 16'h5555, 16'h0);
        bus_write(8'h7C, 32'h0);

        // R4 command while busy ignored
        launch(1'b0, 5'h0C, 5'h15, 16'hA5A5, 16'h0);
        repeat (50) @(negedge clk);
        bus_write(8'h00, cmd_word(1'b1, 5'h02, 5'h07, 16'h0F0F));
        wait_idle();
        check_result(1'b0, 5'h0C, 5'h15, 16'hA5A5, 16'h0);
        repeat (40) @(negedge clk);
        chk("R4 no second frame", 64'(bitn), 64'd64);
        bus_write(8'h7C, 32'h0);

        // R8 mask and irq
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_read(8'h80, v); chk("R8 mask readback", 64'(v), 64'h10);
        chk("R8 irq low, no cause", {63'b0, irq}, 64'h0);
        launch(1'b1, 5'h05, 5'h02, 16'h0, 16'h3C3C);
        wait_idle();
        @(negedge clk);
        chk("R8 irq on completion", {63'b0, irq}, 64'h1);
        bus_write(8'h80, 32'h0);
        chk("R8 irq masked off", {63'b0, irq}, 64'h0);
        bus_write(8'h80, 32'h10);
        chk("R8 irq unmasked again", {63'b0, irq}, 64'h1);
        bus_write(8'h7C, 32'h0);
        chk("R8 irq after clear", {63'b0, irq}, 64'h0);
        bus_write(8'h80, 32'h0);

        // random commands
        for (int k = 0; k < 14; k++) begin
            logic        rd;
            logic [4:0]  phy, ra;
            logic [15:0] dat, r;
            rd  = 1'($urandom);
            phy = 5'($urandom);
            ra  = 5'($urandom);
            dat = 16'($urandom);
            r   = 16'($urandom);
            full_cmd(rd, phy, ra, dat, r);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule